// File: doc/BRIEF.md
# DRAM Command and Address Decoder

This block sits at the command input of a graphics DRAM model or controller-side monitor. On every rising clock edge where clock enable is high, it takes in the chip-select, row-strobe, column-strobe and write-enable levels together with the bank and address buses. One cycle later it presents a single-cycle strobe naming the decoded command. Beside the strobe it gives the fields that command carries: the row for an activate, and the column with its bank and auto-precharge request for a read or write. A precharge comes with its all-banks selector, and a mode-register write comes with its op-code.

The block also tracks which of the eight banks hold an open row. A command that does not fit the current state of its bank raises an error strobe and leaves that state as it was. Such commands are a read or write aimed at a closed bank, or an activate aimed at a bank that is already open. Address bit 8 is not part of the column. On a read or write it requests auto-precharge, and on a precharge it selects all banks. The column is therefore built from bits 0 to 7 with bit 9 on top.

Top module: `dram_cmd_decoder`

## Requirements
- R1: While chip select (`cs_n`) is sampled high, no command strobe asserts in the following cycle, and neither the held fields nor the bank state change.
- R2: While `cke` is sampled low, no command is accepted: no strobe asserts in the following cycle, and neither the held fields nor the bank state change.
- R3: With `cs_n` low and `cke` high, the levels {ras_n,cas_n,we_n} decode as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-register-set, 111 no-operation. The remaining pattern 110 asserts no strobe. The matching strobe is high for exactly the one cycle after the sampling edge.
- R4: On activate, `row_o` takes `addr[11:0]`, `bank_o` takes `ba`, and the bank is marked open in `bank_open_o` (bit index = bank number).
- R5: On read or write, `col_o` takes {addr[9], addr[7:0]} and `bank_o` takes `ba`. `auto_pre_o` equals `addr[8]` during the strobe cycle and is 0 in every other cycle.
- R6: A legal read or write with `addr[8]` high closes its bank. With `addr[8]` low, the bank stays open.
- R7: On precharge with `addr[8]` high, every bank closes, `pre_all_o` is 1 during the strobe, and `ba` is ignored (`bank_o` keeps its value). With `addr[8]` low, only bank `ba` closes, `bank_o` takes `ba`, and `pre_all_o` is 0.
- R8: On mode-register-set, `mode_op_o` takes `addr[11:0]` unchanged.
- R9: A read or write to a closed bank, or an activate to an open bank, raises `illegal_o` for the strobe cycle. The command strobe and its fields still appear, and `bank_open_o` is left unchanged.
- R10: After reset, all strobes, flags, held fields and `bank_open_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | input | 1 | Clock enable; low blocks command capture |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe level |
| cas_n | input | 1 | Column strobe level |
| we_n | input | 1 | Write-enable level |
| ba | input | 3 | Bank address |
| addr | input | 12 | Address / op-code bus |
| act_o | output | 1 | Activate strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| pre_o | output | 1 | Precharge strobe |
| ref_o | output | 1 | Refresh strobe |
| mrs_o | output | 1 | Mode-register-set strobe |
| nop_o | output | 1 | No-operation strobe |
| row_o | output | 12 | Row of the last activate |
| col_o | output | 9 | Column of the last read/write |
| bank_o | output | 3 | Bank of the last bank-directed command |
| auto_pre_o | output | 1 | Auto-precharge request, valid with rd_o/wr_o |
| pre_all_o | output | 1 | All-banks precharge, valid with pre_o |
| mode_op_o | output | 12 | Op-code of the last mode-register-set |
| bank_open_o | output | 8 | Open-row status per bank |
| illegal_o | output | 1 | Command illegal for bank state |

## Verification
The assertions check on every cycle that a high chip select or a low clock enable yields no strobe, and that a low clock enable freezes the bank state. They also check that an illegal command leaves the bank vector untouched, that a legal activate leaves its bank open, that an auto-precharged access leaves it closed, and that an all-banks precharge empties the vector. The exact decode of every pin pattern, the bit positions of the column and the auto-precharge flag, and whether held fields keep their value can only be shown by the bench's sweep. That sweep covers every pin pattern across all banks and many addresses, against a bank-state model.

// File: rtl/cmddec_pkg.sv
package cmddec_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_REF  = 3'd5,
    CMD_MRS  = 3'd6,
    CMD_NOP  = 3'd7
  } dram_cmd_e;

  // Maps the three strobe levels (chip select already low) to a command.
  function automatic dram_cmd_e decode_pins(input logic ras_n, input logic cas_n,
                                            input logic we_n);
    dram_cmd_e c;
    case ({ras_n, cas_n, we_n})
      3'b011:  c = CMD_ACT;
      3'b101:  c = CMD_RD;
      3'b100:  c = CMD_WR;
      3'b010:  c = CMD_PRE;
      3'b001:  c = CMD_REF;
      3'b000:  c = CMD_MRS;
      3'b111:  c = CMD_NOP;
      default: c = CMD_IDLE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/cmd_reset_sync.sv
module cmd_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/cmd_field_decode.sv
module cmd_field_decode
  import cmddec_pkg::*;
#(
  parameter int ADDR_BITS = 12,
  parameter int AP_BIT    = 8,
  localparam int COL_BITS = AP_BIT + 1
) (
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [ADDR_BITS-1:0] addr,
  output dram_cmd_e            cmd,
  output logic [COL_BITS-1:0]  col,
  output logic                 ap_flag
);
  always_comb begin
    if (cke && !cs_n) cmd = decode_pins(ras_n, cas_n, we_n);
    else              cmd = CMD_IDLE;
  end

  // The flag bit is lifted out; the bit above it becomes the column MSB.
  assign col     = {addr[AP_BIT+1], addr[AP_BIT-1:0]};
  assign ap_flag = addr[AP_BIT];
endmodule

// File: rtl/bank_state_tracker.sv
module bank_state_tracker
  import cmddec_pkg::*;
#(
  parameter int BANK_BITS = 3,
  localparam int NUM_BANKS = 1 << BANK_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  dram_cmd_e            cmd,
  input  logic [BANK_BITS-1:0] bank,
  input  logic                 ap_flag,
  output logic [NUM_BANKS-1:0] open_o,
  output logic                 illegal_o
);
  logic [NUM_BANKS-1:0] open_q, open_nx;
  logic                 illegal_q, illegal_nx;
  logic                 target_open;

  assign target_open = open_q[bank];

  always_comb begin
    illegal_nx = 1'b0;
    case (cmd)
      CMD_ACT:        illegal_nx = target_open;
      CMD_RD, CMD_WR: illegal_nx = !target_open;
      default:        illegal_nx = 1'b0;
    endcase
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit;
    assign hit = (bank == BANK_BITS'(g));
    always_comb begin
      open_nx[g] = open_q[g];
      case (cmd)
        CMD_ACT:        if (hit && !open_q[g]) open_nx[g] = 1'b1;
        CMD_RD, CMD_WR: if (hit && open_q[g] && ap_flag) open_nx[g] = 1'b0;
        CMD_PRE:        if (ap_flag || hit) open_nx[g] = 1'b0;
        default:        open_nx[g] = open_q[g];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= '0;
      illegal_q <= 1'b0;
    end else begin
      open_q    <= open_nx;
      illegal_q <= illegal_nx;
    end
  end

  assign open_o    = open_q;
  assign illegal_o = illegal_q;

  // R9
  illegal_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_q |-> $stable(open_q));
endmodule

// File: rtl/dram_cmd_decoder.sv
module dram_cmd_decoder
  import cmddec_pkg::*;
#(
  parameter int ADDR_BITS = 12,
  parameter int BANK_BITS = 3,
  parameter int AP_BIT    = 8,
  localparam int COL_BITS  = AP_BIT + 1,
  localparam int NUM_BANKS = 1 << BANK_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BANK_BITS-1:0] ba,
  input  logic [ADDR_BITS-1:0] addr,
  output logic                 act_o,
  output logic                 rd_o,
  output logic                 wr_o,
  output logic                 pre_o,
  output logic                 ref_o,
  output logic                 mrs_o,
  output logic                 nop_o,
  output logic [ADDR_BITS-1:0] row_o,
  output logic [COL_BITS-1:0]  col_o,
  output logic [BANK_BITS-1:0] bank_o,
  output logic                 auto_pre_o,
  output logic                 pre_all_o,
  output logic [ADDR_BITS-1:0] mode_op_o,
  output logic [NUM_BANKS-1:0] bank_open_o,
  output logic                 illegal_o
);
  logic                 rst_sync_n;
  dram_cmd_e            cmd_d, cmd_q;
  logic [COL_BITS-1:0]  col_d;
  logic                 ap_d;

  logic [ADDR_BITS-1:0] row_q, row_nx, mop_q, mop_nx;
  logic [COL_BITS-1:0]  col_q, col_nx;
  logic [BANK_BITS-1:0] bank_q, bank_nx;
  logic                 ap_q, ap_nx, all_q, all_nx;

  cmd_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cmd_field_decode #(.ADDR_BITS(ADDR_BITS), .AP_BIT(AP_BIT)) u_dec (
    .cke     (cke),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .addr    (addr),
    .cmd     (cmd_d),
    .col     (col_d),
    .ap_flag (ap_d)
  );

  bank_state_tracker #(.BANK_BITS(BANK_BITS)) u_banks (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd       (cmd_d),
    .bank      (ba),
    .ap_flag   (ap_d),
    .open_o    (bank_open_o),
    .illegal_o (illegal_o)
  );

  // Next-state for held fields and one-cycle flags.
  always_comb begin
    row_nx  = row_q;
    col_nx  = col_q;
    bank_nx = bank_q;
    mop_nx  = mop_q;
    ap_nx   = 1'b0;
    all_nx  = 1'b0;
    case (cmd_d)
      CMD_ACT: begin
        row_nx  = addr;
        bank_nx = ba;
      end
      CMD_RD, CMD_WR: begin
        col_nx  = col_d;
        bank_nx = ba;
        ap_nx   = ap_d;
      end
      CMD_PRE: begin
        all_nx = ap_d;
        if (!ap_d) bank_nx = ba;
      end
      CMD_MRS: mop_nx = addr;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmd_q  <= CMD_IDLE;
      row_q  <= '0;
      col_q  <= '0;
      bank_q <= '0;
      mop_q  <= '0;
      ap_q   <= 1'b0;
      all_q  <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      row_q  <= row_nx;
      col_q  <= col_nx;
      bank_q <= bank_nx;
      mop_q  <= mop_nx;
      ap_q   <= ap_nx;
      all_q  <= all_nx;
    end
  end

  assign act_o      = (cmd_q == CMD_ACT);
  assign rd_o       = (cmd_q == CMD_RD);
  assign wr_o       = (cmd_q == CMD_WR);
  assign pre_o      = (cmd_q == CMD_PRE);
  assign ref_o      = (cmd_q == CMD_REF);
  assign mrs_o      = (cmd_q == CMD_MRS);
  assign nop_o      = (cmd_q == CMD_NOP);
  assign row_o      = row_q;
  assign col_o      = col_q;
  assign bank_o     = bank_q;
  assign mode_op_o  = mop_q;
  assign auto_pre_o = ap_q;
  assign pre_all_o  = all_q;

  // R1
  cs_masks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cke && cs_n) |=> !(act_o || rd_o || wr_o || pre_o || ref_o || mrs_o || nop_o));

  // R2
  cke_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cke |=> !(act_o || rd_o || wr_o || pre_o || ref_o || mrs_o || nop_o));

  // R2
  cke_freezes_banks_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cke |=> $stable(bank_open_o));

  // R4
  act_opens_bank_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    act_o |-> bank_open_o[bank_o]);

  // R6
  ap_closes_bank_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((rd_o || wr_o) && auto_pre_o) |-> !bank_open_o[bank_o]);

  // R6
  no_ap_keeps_open_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((rd_o || wr_o) && !auto_pre_o && !illegal_o) |-> bank_open_o[bank_o]);

  // R7
  pre_all_empties_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pre_o && pre_all_o) |-> (bank_open_o == '0));
endmodule

// File: tb/tb_dram_cmd_decoder.sv
`timescale 1ns/1ps
module tb_dram_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke, cs_n, ras_n, cas_n, we_n;
  logic [2:0]  ba;
  logic [11:0] addr;
  logic        act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, nop_o;
  logic [11:0] row_o, mode_op_o;
  logic [8:0]  col_o;
  logic [2:0]  bank_o;
  logic        auto_pre_o, pre_all_o, illegal_o;
  logic [7:0]  bank_open_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [7:0]  m_open;
  logic [11:0] m_row, m_mop;
  logic [8:0]  m_col;
  logic [2:0]  m_bank;

  always #10 clk = ~clk;

  dram_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .act_o(act_o), .rd_o(rd_o), .wr_o(wr_o), .pre_o(pre_o), .ref_o(ref_o),
    .mrs_o(mrs_o), .nop_o(nop_o), .row_o(row_o), .col_o(col_o),
    .bank_o(bank_o), .auto_pre_o(auto_pre_o), .pre_all_o(pre_all_o),
    .mode_op_o(mode_op_o), .bank_open_o(bank_open_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Drive one command at a negedge; compare at the next negedge.
  task automatic step(input logic k, input logic c, input logic [2:0] rcw,
                      input logic [2:0] b, input logic [11:0] a);
    logic [6:0]  e_strb;
    logic        e_ill, e_ap, e_all;
    logic [7:0]  e_open;
    string       tag;
    cke = k; cs_n = c; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
    e_strb = '0; e_ill = 0; e_ap = 0; e_all = 0; e_open = m_open;
    tag = !k ? "R2" : (c ? "R1" : "R3");
    if (k && !c) begin
      case (rcw)
        3'b011: begin // activate
          e_strb = 7'b1000000; m_row = a; m_bank = b;
          if (m_open[b]) e_ill = 1; else e_open[b] = 1'b1;
        end
        3'b101, 3'b100: begin // read, write
          e_strb = (rcw == 3'b101) ? 7'b0100000 : 7'b0010000;
          m_col = {a[9], a[7:0]}; m_bank = b; e_ap = a[8];
          if (!m_open[b]) e_ill = 1; else if (a[8]) e_open[b] = 1'b0;
        end
        3'b010: begin // precharge
          e_strb = 7'b0001000; e_all = a[8];
          if (a[8]) e_open = '0;
          else begin e_open[b] = 1'b0; m_bank = b; end
        end
        3'b001: e_strb = 7'b0000100;
        3'b000: begin e_strb = 7'b0000010; m_mop = a; end
        3'b111: e_strb = 7'b0000001;
        default: e_strb = '0; // reserved pattern
      endcase
    end
    m_open = e_open;
    @(negedge clk);
    chk(tag, "strobes", {25'd0, act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, nop_o}, {25'd0, e_strb});
    chk("R9", "illegal", {31'd0, illegal_o}, {31'd0, e_ill});
    chk("R4 R6 R7 R9", "bank_open", {24'd0, bank_open_o}, {24'd0, m_open});
    chk("R4", "row", {20'd0, row_o}, {20'd0, m_row});
    chk("R5", "col", {23'd0, col_o}, {23'd0, m_col});
    chk("R5", "bank", {29'd0, bank_o}, {29'd0, m_bank});
    chk("R5", "auto_pre", {31'd0, auto_pre_o}, {31'd0, e_ap});
    chk("R7", "pre_all", {31'd0, pre_all_o}, {31'd0, e_all});
    chk("R8", "mode_op", {20'd0, mode_op_o}, {20'd0, m_mop});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cke = 1; cs_n = 1; {ras_n, cas_n, we_n} = 3'b111; ba = 0; addr = 0;
    m_open = 0; m_row = 0; m_mop = 0; m_col = 0; m_bank = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "strobes", {25'd0, act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, nop_o}, 32'd0);
    chk("R10", "bank_open", {24'd0, bank_open_o}, 32'd0);
    chk("R10", "fields", {row_o, col_o, bank_o, auto_pre_o, pre_all_o, illegal_o}, 32'd0);
    chk("R10", "mode_op", {20'd0, mode_op_o}, 32'd0);

    // directed: open every bank, then all-banks precharge with ba ignored
    for (int b = 0; b < 8; b++) step(1'b1, 1'b0, 3'b011, 3'(b), 12'(b * 291));
    step(1'b1, 1'b0, 3'b010, 3'd5, 12'h100);
    // R9: read of closed bank; R6: write with auto-precharge
    step(1'b1, 1'b0, 3'b101, 3'd2, 12'h2AB);
    step(1'b1, 1'b0, 3'b011, 3'd2, 12'hFFF);
    step(1'b1, 1'b0, 3'b100, 3'd2, 12'h3FF);

    // sweep all pin patterns over all banks, cke and cs, varied addresses
    for (int rep = 0; rep < 4; rep++)
      for (int b = 0; b < 8; b++)
        for (int p = 0; p < 16; p++)
          step((rep != 2) || b[0], p[3], 3'(p), 3'(b),
               12'((rep * 1031 + b * 397 + p * 113) & 12'hFFF));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule